// File: doc/BRIEF.md
# Transceiver Receive Output Control

This block sits on the digital side of a serial transceiver and chooses, on every reference clock edge, what the parallel receive outputs and the serial transmit driver do. Six conditions compete for those pins: the start-up hold after power is applied, power-down, loss of incoming signal, pseudo-random self-test checking, loopback and plain data delivery. Outputs that would be high-impedance on the pads are modelled as output-enable bits, so a pad ring can place the tri-state buffers.

After the asynchronous power-up pulse `rst_n` is released, an internal counter keeps the block in its start-up hold for `POR_CYCLES` reference cycles. After that hold, the operating mode is chosen by fixed priority: power-down (enable low), then loss of signal, then self-test, then data. Loopback is separate from this order. It changes only the serial driver enable and the internal path select. Every output is registered. A change on the inputs sampled at one rising edge appears on the outputs immediately after that edge.

Top module: `rx_out_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first `POR_CYCLES` rising edges after it rises, `rx_clk_gate`, `rx_data_oe`, `rk_hi_oe`, `rk_lo_oe`, `tx_ser_oe` and `loop_sel` are all 0. From edge `POR_CYCLES+1` on, they follow the mode rules below.
- R2: In data mode (out of hold, `enable`=1, `los_flag`=0, `prbs_en`=0), `rx_data_out`, `rk_hi_out` and `rk_lo_out` equal `rx_data_in`, `rk_hi_in` and `rk_lo_in` as sampled at the previous edge. All three enables are 1 and `rx_clk_gate` is 1.
- R3: Out of hold with `enable`=0, `rx_data_oe`, `rk_lo_oe` and `tx_ser_oe` are 0, `rk_hi_oe` is 1 and `rk_hi_out` is 0. This holds whatever `los_flag` and `prbs_en` are.
- R4: Out of hold with `enable`=1 and `los_flag`=1, every bit of `rx_data_out`, `rk_hi_out` and `rk_lo_out` is 1, whatever `prbs_en` is.
- R5: In self-test mode (`enable`=1, `los_flag`=0, `prbs_en`=1), `rk_lo_out` carries the pass flag (1 = no error seen). `rx_data_out` and `rk_hi_out` still pass through.
- R6: The pass flag is 1 while `prbs_en` is 0 and during the hold. It drops to 0 at the edge that samples `prbs_err`=1 with `prbs_en`=1, and it stays 0 until an edge samples `prbs_en`=0.
- R7: Out of hold with `loop_en`=1, `loop_sel` is 1 and `tx_ser_oe` is 0. The receive outputs are the same as with `loop_en`=0.
- R8: `tx_ser_oe` is 1 exactly when the block is out of hold, `enable`=1 and `loop_en`=0.
- R9: Any output whose enable is 0 carries the value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-up pulse, active low |
| enable | input | 1 | 0 selects power-down |
| los_flag | input | 1 | Loss-of-signal flag from the detector |
| prbs_en | input | 1 | Self-test checker enable |
| loop_en | input | 1 | Internal loopback enable |
| prbs_err | input | 1 | Checker reports a bit error this cycle |
| rx_data_in | input | DATA_W | Decoded receive data |
| rk_hi_in | input | 1 | K indicator for the upper byte |
| rk_lo_in | input | 1 | K indicator for the lower byte |
| rx_data_out | output | DATA_W | Receive data bus value |
| rx_data_oe | output | 1 | Receive data bus drive enable |
| rk_hi_out | output | 1 | Upper indicator / loss-of-signal pin value |
| rk_hi_oe | output | 1 | Upper indicator drive enable |
| rk_lo_out | output | 1 | Lower indicator / pass flag pin value |
| rk_lo_oe | output | 1 | Lower indicator drive enable |
| rx_clk_gate | output | 1 | 1 lets the receive clock run, 0 holds it low |
| tx_ser_oe | output | 1 | Serial transmit driver enable |
| loop_sel | output | 1 | Routes serial transmit data to the receiver |

## Verification
The bench builds the block with `DATA_W`=16 and `POR_CYCLES`=20 at `REF_MHZ`=50. With so short a hold, the bench can watch the whole start-up window and the first edge after it. It can also force a second hold by pulsing `rst_n` part way through the run. The full-width bus still lets the forced all-ones pattern of R4 be told apart from passed-through data. Weighted random mixes of the mode inputs reach every combination of the priority order, including sticky pass-flag runs that overlap loss of signal and power-down.

// File: rtl/rxoc_pkg.sv
package rxoc_pkg;

   typedef enum logic [2:0] {
      MODE_HOLD = 3'd0,
      MODE_PDN  = 3'd1,
      MODE_LOS  = 3'd2,
      MODE_TEST = 3'd3,
      MODE_DATA = 3'd4
   } rx_mode_e;

   // fixed priority: start-up hold, power-down, loss of signal, self-test, data
   function automatic rx_mode_e pick_mode(input logic hold, input logic en,
                                          input logic los, input logic test);
      if (hold)      return MODE_HOLD;
      else if (!en)  return MODE_PDN;
      else if (los)  return MODE_LOS;
      else if (test) return MODE_TEST;
      else           return MODE_DATA;
   endfunction

endpackage

// File: rtl/rxoc_por_timer.sv
module rxoc_por_timer #(
   parameter int unsigned CYCLES = 65536
) (
   input  logic clk_ref,
   input  logic rst_n,
   output logic hold
);
   localparam int unsigned CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign hold = (cnt_q != LAST);

   // once the hold has ended it never returns without a reset
   assert_hold_ends_once_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !hold |=> !hold);

endmodule

// File: rtl/rxoc_pass_track.sv
module rxoc_pass_track (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic clr,
   input  logic prbs_en,
   input  logic prbs_err,
   output logic pass_nxt
);
   logic pass_q;

   always_comb begin
      if (clr || !prbs_en) pass_nxt = 1'b1;
      else                 pass_nxt = pass_q & ~prbs_err;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) pass_q <= 1'b1;
      else        pass_q <= pass_nxt;
   end

   assert_pass_sticky_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!pass_q && prbs_en && !clr) |=> !pass_q);

   assert_err_drops_pass_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (prbs_en && prbs_err && !clr) |=> !pass_q);

endmodule

// File: rtl/rxoc_out_stage.sv
module rxoc_out_stage
   import rxoc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  rx_mode_e          mode,
   input  logic              loop_en,
   input  logic              pass_nxt,
   input  logic [DATA_W-1:0] rx_data_in,
   input  logic              rk_hi_in,
   input  logic              rk_lo_in,
   output logic [DATA_W-1:0] rx_data_out,
   output logic              rx_data_oe,
   output logic              rk_hi_out,
   output logic              rk_hi_oe,
   output logic              rk_lo_out,
   output logic              rk_lo_oe,
   output logic              rx_clk_gate,
   output logic              tx_ser_oe,
   output logic              loop_sel
);
   logic [DATA_W-1:0] data_d;
   logic              live, bus_live, hi_d, lo_d;

   assign live     = (mode != MODE_HOLD);
   assign bus_live = live && (mode != MODE_PDN);

   // per-bit selection: forced high on loss of signal, passed through when live
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      always_comb begin
         unique case (mode)
            MODE_LOS:             data_d[b] = 1'b1;
            MODE_TEST, MODE_DATA: data_d[b] = rx_data_in[b];
            default:              data_d[b] = 1'b0;
         endcase
      end
   end

   always_comb begin
      unique case (mode)
         MODE_LOS:  begin hi_d = 1'b1;     lo_d = 1'b1;     end
         MODE_TEST: begin hi_d = rk_hi_in; lo_d = pass_nxt; end
         MODE_DATA: begin hi_d = rk_hi_in; lo_d = rk_lo_in; end
         default:   begin hi_d = 1'b0;     lo_d = 1'b0;     end
      endcase
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_out <= '0;
         rx_data_oe  <= 1'b0;
         rk_hi_out   <= 1'b0;
         rk_hi_oe    <= 1'b0;
         rk_lo_out   <= 1'b0;
         rk_lo_oe    <= 1'b0;
         rx_clk_gate <= 1'b0;
         tx_ser_oe   <= 1'b0;
         loop_sel    <= 1'b0;
      end else begin
         rx_data_out <= data_d;
         rx_data_oe  <= bus_live;
         rk_hi_out   <= hi_d;
         rk_hi_oe    <= live;
         rk_lo_out   <= lo_d;
         rk_lo_oe    <= bus_live;
         rx_clk_gate <= live;
         tx_ser_oe   <= bus_live && !loop_en;
         loop_sel    <= live && loop_en;
      end
   end

endmodule

// File: rtl/rx_out_ctrl.sv
module rx_out_ctrl
   import rxoc_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned POR_CYCLES = 65536,
   parameter int unsigned REF_MHZ    = 100
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              los_flag,
   input  logic              prbs_en,
   input  logic              loop_en,
   input  logic              prbs_err,
   input  logic [DATA_W-1:0] rx_data_in,
   input  logic              rk_hi_in,
   input  logic              rk_lo_in,
   output logic [DATA_W-1:0] rx_data_out,
   output logic              rx_data_oe,
   output logic              rk_hi_out,
   output logic              rk_hi_oe,
   output logic              rk_lo_out,
   output logic              rk_lo_oe,
   output logic              rx_clk_gate,
   output logic              tx_ser_oe,
   output logic              loop_sel
);
   localparam int unsigned MS_CYCLES = REF_MHZ * 1000;

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (POR_CYCLES < 1) begin : g_bad_por
      $error("POR_CYCLES must be at least 1");
   end
   if (POR_CYCLES >= MS_CYCLES) begin : g_por_too_long
      $error("start-up hold must stay below one millisecond of reference clock");
   end

   logic     hold, pass_nxt;
   rx_mode_e mode;

   rxoc_por_timer #(.CYCLES(POR_CYCLES)) i_timer (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .hold    (hold)
   );

   assign mode = pick_mode(hold, enable, los_flag, prbs_en);

   rxoc_pass_track i_pass (
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .clr      (hold),
      .prbs_en  (prbs_en),
      .prbs_err (prbs_err),
      .pass_nxt (pass_nxt)
   );

   rxoc_out_stage #(.DATA_W(DATA_W)) i_out (
      .clk_ref     (clk_ref),
      .rst_n       (rst_n),
      .mode        (mode),
      .loop_en     (loop_en),
      .pass_nxt    (pass_nxt),
      .rx_data_in  (rx_data_in),
      .rk_hi_in    (rk_hi_in),
      .rk_lo_in    (rk_lo_in),
      .rx_data_out (rx_data_out),
      .rx_data_oe  (rx_data_oe),
      .rk_hi_out   (rk_hi_out),
      .rk_hi_oe    (rk_hi_oe),
      .rk_lo_out   (rk_lo_out),
      .rk_lo_oe    (rk_lo_oe),
      .rx_clk_gate (rx_clk_gate),
      .tx_ser_oe   (tx_ser_oe),
      .loop_sel    (loop_sel)
   );

   assert_clk_held_in_hold_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      hold |=> (!rx_clk_gate && !rx_data_oe && !rk_hi_oe && !rk_lo_oe));

   assert_pdn_hiz_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!hold && !enable) |=> (!tx_ser_oe && !rx_data_oe && !rk_lo_oe && rk_hi_oe));

   assert_los_all_high_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!hold && enable && los_flag) |=> (&rx_data_out && rk_hi_out && rk_lo_out));

   assert_loop_kills_driver_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!hold && loop_en) |=> (loop_sel && !tx_ser_oe));

   assert_disabled_bus_zero_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !rx_data_oe |-> (rx_data_out == '0));

endmodule

// File: tb/test_rx_out_ctrl.sv
module test_rx_out_ctrl;
   localparam int DW  = 16;
   localparam int POR = 20;

   logic          clk_ref = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b1, los_flag = 1'b0, prbs_en = 1'b0, loop_en = 1'b0, prbs_err = 1'b0;
   logic [DW-1:0] rx_data_in = '0;
   logic          rk_hi_in = 1'b0, rk_lo_in = 1'b0;
   logic [DW-1:0] rx_data_out;
   logic          rx_data_oe, rk_hi_out, rk_hi_oe, rk_lo_out, rk_lo_oe;
   logic          rx_clk_gate, tx_ser_oe, loop_sel;

   rx_out_ctrl #(.DATA_W(DW), .POR_CYCLES(POR), .REF_MHZ(50)) i_rx_out_ctrl (.*);

   always #10 clk_ref = ~clk_ref;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   // behavioural reference: expected pin values after each edge
   int          m_cnt;
   bit          m_pass;
   logic [DW-1:0] e_data;
   logic        e_doe, e_hi, e_hoe, e_lo, e_loe, e_clk, e_txoe, e_lsel;

   task automatic set_quiet();
      e_data = '0; e_doe = 0; e_hi = 0; e_hoe = 0; e_lo = 0; e_loe = 0;
      e_clk = 0; e_txoe = 0; e_lsel = 0;
   endtask

   always @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_pass = 1; set_quiet();
      end else begin
         bit in_hold;
         in_hold = (m_cnt < POR);
         if (in_hold) m_cnt++;
         if (in_hold || !prbs_en) m_pass = 1;
         else if (prbs_err)       m_pass = 0;
         set_quiet();
         if (!in_hold) begin
            e_clk = 1; e_hoe = 1; e_lsel = loop_en;
            if (!enable) begin
               e_hi = 0;
            end else begin
               e_doe = 1; e_loe = 1; e_txoe = !loop_en;
               if (los_flag)     begin e_data = '1; e_hi = 1; e_lo = 1; end
               else if (prbs_en) begin e_data = rx_data_in; e_hi = rk_hi_in; e_lo = m_pass; end
               else              begin e_data = rx_data_in; e_hi = rk_hi_in; e_lo = rk_lo_in; end
            end
         end
      end
   end

   task automatic cmp(input string req, input string name, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s at %0t: actual=%h expected=%h", req, name, $time, act, exp);
      end
   endtask

   // requirement tag chosen by the mode currently in force
   function automatic string tag();
      if (m_cnt < POR || !rst_n) return "R1";
      if (!enable) return "R3";
      if (los_flag) return "R4";
      if (prbs_en) return "R5/R6";
      return "R2";
   endfunction

   always @(negedge clk_ref) if (!done) begin
      string t;
      t = tag();
      vectors++;
      cmp(t,    "rx_data_out", rx_data_out, e_data);
      cmp(t,    "rx_data_oe",  DW'(rx_data_oe), DW'(e_doe));
      cmp(t,    "rk_hi_out",   DW'(rk_hi_out), DW'(e_hi));
      cmp(t,    "rk_hi_oe",    DW'(rk_hi_oe), DW'(e_hoe));
      cmp(t,    "rk_lo_out",   DW'(rk_lo_out), DW'(e_lo));
      cmp(t,    "rk_lo_oe",    DW'(rk_lo_oe), DW'(e_loe));
      cmp("R1", "rx_clk_gate", DW'(rx_clk_gate), DW'(e_clk));
      cmp("R8", "tx_ser_oe",   DW'(tx_ser_oe), DW'(e_txoe));
      cmp("R7", "loop_sel",    DW'(loop_sel), DW'(e_lsel));
      if (!rx_data_oe && rx_data_out !== '0) begin
         miscompares++;
         $display("FAIL R9 bus not zero when disabled: actual=%h expected=0", rx_data_out);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk_ref); #5;
         rx_data_in = DW'($urandom);
         rk_hi_in   = 1'($urandom);
         rk_lo_in   = 1'($urandom);
      end
   endtask

   task automatic mode_set(input bit en, input bit los, input bit pe, input bit le, input bit err);
      enable = en; los_flag = los; prbs_en = pe; loop_en = le; prbs_err = err;
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      miscompares++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset then full start-up hold with data mode requested
      step(3);
      #2 rst_n = 1'b1;
      step(POR + 5);
      // R2: plain data
      mode_set(1, 0, 0, 0, 0); step(10);
      // R5, R6: self-test, error pulse, sticky, release
      mode_set(1, 0, 1, 0, 0); step(4);
      prbs_err = 1; step(1); prbs_err = 0; step(5);
      prbs_en = 0; step(2); prbs_en = 1; step(3);
      // R4: loss of signal beats self-test
      mode_set(1, 1, 1, 0, 1); step(4);
      mode_set(1, 0, 1, 0, 0); step(3);
      // R3: power-down beats loss of signal
      mode_set(0, 1, 1, 0, 0); step(4);
      mode_set(0, 0, 0, 1, 0); step(3);
      // R7, R8: loopback alone and with self-test
      mode_set(1, 0, 0, 1, 0); step(5);
      mode_set(1, 0, 1, 1, 0); step(3); prbs_err = 1; step(1); prbs_err = 0; step(3);
      // R1: a second power-up pulse mid-run restarts the hold
      mode_set(1, 0, 0, 0, 0);
      @(posedge clk_ref); #5 rst_n = 1'b0; step(2); #2 rst_n = 1'b1;
      step(POR + 4);
      // weighted random mixture of all mode inputs
      for (int k = 0; k < 3000; k++) begin
         mode_set(($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 3) == 0,
                  ($urandom % 4) == 0, ($urandom % 10) == 0);
         step(1 + ($urandom % 3));
      end
      step(2);
      finish_run();
   end

endmodule